// File: doc/BRIEF.md
# Column data serializer with masking

This block sits between the column discriminators and the digital output pads of a pixel sensor readout. At each row boundary it takes one row of binary column results and places it in a shadow register. It then sends the row out on a set of parallel lanes, one bit per lane every two main clocks. A digital sample clock runs at half the main clock rate, and each new bit appears on the lanes at the moment that clock falls. The next row can be presented while the current one is still being sent. The sequencer presents rows exactly 16 main clocks apart, so the lanes never stop inside a frame.

Before a row is captured, a per-column disable mask silences noisy columns. Two debug modes replace the row with a programmable test pattern. The first replaces every row. The second replaces only the appended marker rows that the sequencer flags after the last matrix row.

A frame marker output helps the acquisition system find frame boundaries. It is armed for a frame when a sync request was seen during the previous frame. The output is also held low whenever the request input is low. In marker mode 0 it pulses during the final bit of the frame. In marker mode 1 it copies the sample clock for the whole frame.

Top module: `col_serializer`

## Requirements
- R1: Lane k carries columns 8k+7 down to 8k of the captured row, the highest-numbered column first and column 8k last, one bit per two main clocks.
- R2: `dclk` is high only on the second main clock of each bit period, so it is never high for two cycles in a row. `dout` changes only on the clock at which `dclk` falls. `dclk` stays low while no row is being sent.
- R3: A set bit in `disable_mask` forces the matching column of real row data to 0 on its lane. The mask does not act on pattern rows.
- R4: While `pattern_only` is high at a row load, the row sent is the `pattern` input, and `row_data` is ignored.
- R5: While `line_marker` is high, rows loaded with `appended_row` high carry `pattern`. Other rows carry masked `row_data`.
- R6: While `sync_req` is low, `marker_d` is 0.
- R7: In marker mode 0 (`marker_mode`=0), an armed frame drives `marker_d` high for the two main clocks of the last bit of the row loaded with `last_row` high, and at no other time in that frame.
- R8: In marker mode 1 (`marker_mode`=1), an armed frame drives `marker_d` equal to `dclk` from the first bit of the frame, giving 8 high cycles per row.
- R9: A frame is armed only if `sync_req` was high on some clock after the previous frame's first-row load, up to and including its own first-row load (`row_load` with `first_row`). Before the first frame after reset, nothing is armed.
- R10: After the clock edge that samples `row_load` high, the first bit of the new row is on `dout`. Rows loaded every 16 clocks are sent with no gap and no repeated bit.
- R11: After reset, `dout`, `dclk` and `marker_d` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_load | input | 1 | Captures the presented row into the shadow register |
| first_row | input | 1 | Qualifies `row_load` as the first row of a frame |
| last_row | input | 1 | Qualifies `row_load` as the last row of a frame |
| appended_row | input | 1 | Qualifies `row_load` as an appended marker row |
| row_data | input | 128 | Discriminator results, one bit per column |
| disable_mask | input | 128 | One bit per column; a set bit silences that column |
| pattern | input | 128 | Test pattern used in place of row data |
| pattern_only | input | 1 | Replace every row by `pattern` |
| line_marker | input | 1 | Replace appended rows by `pattern` |
| marker_mode | input | 1 | 0: pulse on last frame bit; 1: copy of `dclk` |
| sync_req | input | 1 | Arms markers for the next frame; gates the marker output |
| dout | output | 16 | Serial data, one bit per lane |
| dclk | output | 1 | Digital sample clock at half the main rate |
| marker_d | output | 1 | Frame marker |

## Verification
The checker watches the clock shape and timing on every cycle. It confirms that `dclk` never stays high for two cycles and that `dout` holds while `dclk` is high. It checks that masked columns come out as zero and that pattern rows reproduce the pattern on the first bit after the load. It also checks that the marker is held low without a request, that in mode 1 it rises only with `dclk`, and that in mode 0 it falls right after the final bit. What only the bench's scenarios can show is the full bit order across all eight bits of every lane over back-to-back rows. The same holds for arming one frame late: a request made during one frame must produce markers in the next, and a frame with no request must produce none. The exact number of marker cycles per frame in each mode is likewise left to the bench.

// File: rtl/col_serializer.sv
module col_serializer #(
  parameter int LANES  = 16,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     row_load,
  input  logic                     first_row,
  input  logic                     last_row,
  input  logic                     appended_row,
  input  logic [LANES*LANE_W-1:0]  row_data,
  input  logic [LANES*LANE_W-1:0]  disable_mask,
  input  logic [LANES*LANE_W-1:0]  pattern,
  input  logic                     pattern_only,
  input  logic                     line_marker,
  input  logic                     marker_mode,
  input  logic                     sync_req,
  output logic [LANES-1:0]         dout,
  output logic                     dclk,
  output logic                     marker_d
);
  localparam int COLS  = LANES * LANE_W;
  localparam int CNT_W = $clog2(LANE_W) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(2 * LANE_W - 1);
  localparam logic [CNT_W-2:0] BIT_LAST = (CNT_W-1)'(LANE_W - 1);

  logic [COLS-1:0]  shadow;
  logic [COLS-1:0]  load_val;
  logic [CNT_W-1:0] cnt;
  logic             active;
  logic             row_last;
  logic             armed;
  logic             req_seen;
  logic             use_pat;
  logic             frame_go;
  logic             last_bit;

  assign use_pat  = pattern_only | (line_marker & appended_row);
  assign load_val = use_pat ? pattern : (row_data & ~disable_mask);
  assign frame_go = row_load & first_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow   <= '0;
      cnt      <= '0;
      active   <= 1'b0;
      row_last <= 1'b0;
    end else if (row_load) begin
      shadow   <= load_val;
      cnt      <= '0;
      active   <= 1'b1;
      row_last <= last_row;
    end else if (active) begin
      cnt <= cnt + 1'b1;
      if (cnt[0]) begin
        for (int k = 0; k < LANES; k++)
          shadow[k*LANE_W +: LANE_W] <= {shadow[k*LANE_W +: LANE_W-1], 1'b0};
      end
      if (cnt == CNT_LAST)
        active <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      req_seen <= 1'b0;
    end else if (frame_go) begin
      armed    <= req_seen | sync_req;
      req_seen <= 1'b0;
    end else begin
      req_seen <= req_seen | sync_req;
    end
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign dout[g] = shadow[g*LANE_W + LANE_W - 1];
    end
  endgenerate

  assign dclk     = active & cnt[0];
  assign last_bit = active & row_last & (cnt[CNT_W-1:1] == BIT_LAST);
  assign marker_d = armed & sync_req & (marker_mode ? dclk : last_bit);
endmodule

// File: rtl/col_serializer_chk.sv
module col_serializer_chk #(
  parameter int LANES  = 16,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    row_load,
  input logic                    appended_row,
  input logic [LANES*LANE_W-1:0] disable_mask,
  input logic [LANES*LANE_W-1:0] pattern,
  input logic                    pattern_only,
  input logic                    line_marker,
  input logic                    marker_mode,
  input logic                    sync_req,
  input logic [LANES-1:0]        dout,
  input logic                    dclk,
  input logic                    marker_d
);
  logic [LANES-1:0] mask_msb;
  logic [LANES-1:0] pat_msb;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      mask_msb[k] = disable_mask[k*LANE_W + LANE_W - 1];
      pat_msb[k]  = pattern[k*LANE_W + LANE_W - 1];
    end
  end

  AST_DCLK_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |=> !dclk); // R2
  AST_DOUT_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |-> $stable(dout)); // R2
  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (row_load && !pattern_only && !(line_marker && appended_row)) |=> ((dout & $past(mask_msb)) == '0)); // R3
  AST_PATTERN_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (row_load && pattern_only) |=> (dout == $past(pat_msb))); // R4
  AST_PATTERN_APPENDED: assert property (@(posedge clk) disable iff (!rst_n)
    (row_load && line_marker && appended_row) |=> (dout == $past(pat_msb))); // R5
  AST_MARKER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_req |-> !marker_d); // R6
  AST_MODE0_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!marker_mode && marker_d && dclk && $stable(marker_mode)) |=> !marker_d); // R7
  AST_MODE1_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (marker_mode && marker_d) |-> dclk); // R8
endmodule

bind col_serializer col_serializer_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_load(row_load), .appended_row(appended_row),
  .disable_mask(disable_mask), .pattern(pattern), .pattern_only(pattern_only),
  .line_marker(line_marker), .marker_mode(marker_mode), .sync_req(sync_req),
  .dout(dout), .dclk(dclk), .marker_d(marker_d)
);

// File: tb/test_col_serializer.sv
module test_col_serializer;
  localparam int COLS = 128;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             row_load = 1'b0;
  logic             first_row = 1'b0;
  logic             last_row = 1'b0;
  logic             appended_row = 1'b0;
  logic [COLS-1:0]  row_data = '0;
  logic [COLS-1:0]  disable_mask = '0;
  logic [COLS-1:0]  pattern = '0;
  logic             pattern_only = 1'b0;
  logic             line_marker = 1'b0;
  logic             marker_mode = 1'b0;
  logic             sync_req = 1'b0;
  logic [15:0]      dout;
  logic             dclk;
  logic             marker_d;

  int n_checks = 0, n_bad = 0;
  int mon_checks = 0, mon_bad = 0;
  int mk_count = 0;
  int cyc = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  col_serializer i_col_serializer (
    .clk(clk), .rst_n(rst_n), .row_load(row_load), .first_row(first_row),
    .last_row(last_row), .appended_row(appended_row), .row_data(row_data),
    .disable_mask(disable_mask), .pattern(pattern), .pattern_only(pattern_only),
    .line_marker(line_marker), .marker_mode(marker_mode), .sync_req(sync_req),
    .dout(dout), .dclk(dclk), .marker_d(marker_d)
  );

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [COLS-1:0] row_val(input int i);
    logic [31:0] r;
    r = 32'hA5C3_0F17 ^ (32'h0103_0507 * (i + 1));
    return {r, r ^ 32'hFFFF_0000, ~r, {r[28:0], 3'b101}};
  endfunction

  function automatic logic [15:0] word_at(input logic [COLS-1:0] v, input int b);
    logic [15:0] w;
    for (int k = 0; k < 16; k++) w[k] = v[8*k + 7 - b];
    return w;
  endfunction

  // sync_ctl: 0 keep, 1 raise after first load, 2 drop after first load
  task automatic frame(input int nrows, input int nappend, input int sync_ctl,
                       input int exp_mk, input string dtag, input string mtag);
    int mk_start;
    int total;
    logic [COLS-1:0] d, e;
    mk_start = mk_count;
    total = nrows + nappend;
    for (int i = 0; i < total; i++) begin
      d = row_val(i + 7 * total);
      if (pattern_only || (line_marker && i >= nrows)) e = pattern;
      else e = d & ~disable_mask;
      for (int b = 0; b < 8; b++) begin
        exp_q.push_back(word_at(e, b));
        tag_q.push_back(dtag);
      end
      row_data     = d;
      row_load     = 1'b1;
      first_row    = (i == 0);
      last_row     = (i == total - 1);
      appended_row = (i >= nrows);
      tick();
      row_load = 1'b0;
      first_row = 1'b0;
      last_row = 1'b0;
      appended_row = 1'b0;
      if (i == 0 && sync_ctl == 1) sync_req = 1'b1;
      if (i == 0 && sync_ctl == 2) sync_req = 1'b0;
      for (int t = 0; t < 14; t++) tick();
      if (i < total - 1) tick();
    end
    for (int t = 0; t < 4; t++) tick();
    check((mk_count - mk_start) == exp_mk, mtag, mk_count - mk_start, exp_mk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (marker_d) mk_count++;
        if (dclk) begin
          mon_checks++;
          if (exp_q.size() == 0) begin
            mon_bad++;
            $display("FAIL R10 unexpected bit actual=%0h expected=none", dout);
          end else begin
            logic [15:0] w;
            string tg;
            w = exp_q.pop_front();
            tg = tag_q.pop_front();
            if (dout !== w) begin
              mon_bad++;
              $display("FAIL %s actual=%0h expected=%0h", tg, dout, w);
            end
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", n_checks + mon_checks + 1, n_bad + mon_bad + 1);
      $finish;
    end
  end

  initial begin
    pattern = {32'hAAFF_FFFF, 32'hAAAA_AAAA, 32'h5555_5555, 32'h22FF_FF11};
    tick(); tick();
    check(dout == 16'h0, "R11", dout, 0);
    check(dclk == 1'b0, "R11", dclk, 0);
    check(marker_d == 1'b0, "R11", marker_d, 0);
    rst_n = 1'b1;
    tick(); tick();
    // R1 R10 R9: request raised during the first frame, no marker yet
    frame(3, 0, 1, 0, "R1", "R9");
    // R3 R7: masked data, mode 0 pulse on final bit
    disable_mask = {32'hF000_000F, 32'h8080_8080, 32'h0000_FFFF, 32'h0101_0101};
    frame(3, 0, 0, 2, "R3", "R7");
    // R4 R8: pattern only, mask ignored, mode 1 follows dclk
    marker_mode = 1'b1;
    pattern_only = 1'b1;
    frame(2, 0, 0, 16, "R4", "R8");
    // R5 R6: appended rows carry pattern, request dropped so marker silent
    pattern_only = 1'b0;
    line_marker = 1'b1;
    frame(2, 2, 2, 0, "R5", "R6");
    // R9: no request in the previous frame, no marker
    line_marker = 1'b0;
    marker_mode = 1'b0;
    disable_mask = '0;
    frame(2, 0, 1, 0, "R10", "R9");
    frame(4, 0, 0, 2, "R1", "R7");
    for (int t = 0; t < 5; t++) tick();
    check(dclk == 1'b0, "R2", dclk, 0);
    check(exp_q.size() == 0, "R10", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", n_checks + mon_checks, n_bad + mon_bad);
    $finish;
  end
endmodule